// File: doc/BRIEF.md
# Three-Bus Processor Datapath

This block is the datapath and step sequencer of a small processor built around three internal buses. Two source buses feed the ALU, and its result travels on a third bus. The register file has two read ports, one on each source bus, and one write port fed from the result bus. The ALU either adds the two source buses or passes the second source bus straight through to the result bus. The program counter has its own incrementer, so instruction fetch never needs the ALU adder.

Each instruction takes four steps. In step 1 the PC goes through the ALU pass-through into the memory address register, a read starts, and the PC advances by 4. In step 2 the block waits for the memory to signal completion and then latches the returned word into the data register. In step 3 the data register is passed through the ALU into the instruction register. In step 4 two registers named by the instruction are added and the sum is written to a third register, which ends the instruction.

Each register write is also shown for one cycle on a write-back port, so a host can observe the results.

Top module: `tribus_core`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `phase` is 0 and `mem_rd`, `wb_en`, `instr_end` and `ir` are all 0. Reset loads register k of the file with the value k, and it clears the PC to 0.
- R2: `phase` encodes the step: 0 is fetch, 1 is wait, 2 is decode and 3 is execute. In the cycle after a fetch step, `mem_rd` is high and `mem_addr` equals the PC that was current during fetch. Successive instruction fetches use addresses 0, 4, 8 and so on.
- R3: In the wait step without `mem_done`, the block stays in the wait step with `mem_rd` held high and `mem_addr` unchanged, for any number of cycles.
- R4: A wait-step cycle with `mem_done` high captures `mem_rdata`, drops `mem_rd` and moves to the decode step.
- R5: The decode step copies the captured word into `ir`, visible from the following cycle, and moves to the execute step.
- R6: The execute step writes the 32-bit modular sum of register `ir[19:16]` and register `ir[15:12]` into register `ir[23:20]`. All other `ir` bits are ignored. For exactly one cycle afterwards, `wb_en` is 1, `wb_idx` shows the destination and `wb_data` shows the sum.
- R7: The execute step ends the instruction. `instr_end` pulses for one cycle together with `wb_en`, and `phase` returns to 0.
- R8: `mem_done` outside the wait step has no effect. It does not change `ir`, the step order or the written result.
- R9: When the destination is also a source, the sum uses the register's value from before the write. The new value is visible to the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Memory address register |
| mem_rd | output | 1 | Read request, high while waiting for memory |
| mem_rdata | input | 32 | Word returned by memory |
| mem_done | input | 1 | Memory completion strobe |
| phase | output | 2 | Current step (0 fetch, 1 wait, 2 decode, 3 execute) |
| ir | output | 32 | Instruction register |
| wb_en | output | 1 | One-cycle register write indication |
| wb_idx | output | 4 | Destination register of the write |
| wb_data | output | 32 | Value written |
| instr_end | output | 1 | One-cycle end-of-instruction pulse |

## Verification
The embedded assertions check the step order on every cycle: a wait step without completion repeats, decode is always followed by execute, and execute is always followed by fetch. They also check that every fetch advances the PC by 4, that the read request is only high in the wait step, that `ir` changes only after a decode step, and that the write-back pulse comes only from an execute step. The correctness of the sums, the bit positions of the register fields, the reset seeding of the register file, the read-before-write case and the ignored stray completions depend on data values, so only the bench scenarios show them, by comparing against a register model kept in the bench.

// File: rtl/tribus_pkg.sv
package tribus_pkg;
  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_WAIT   = 2'd1,
    PH_DECODE = 2'd2,
    PH_EXEC   = 2'd3
  } phase_t;

  typedef enum logic {
    ALU_PASS_B = 1'b0,
    ALU_ADD    = 1'b1
  } alu_op_t;
endpackage

// File: rtl/tribus_regfile.sv
module tribus_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] ra_a,
  input  logic [IW-1:0] ra_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  input  logic          we,
  input  logic [IW-1:0] wa,
  input  logic [DW-1:0] wd
);
  logic [DW-1:0] mem [NREG];

  // Seeded contents on reset; synchronous single write port.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= DW'(i);
    end else if (we) begin
      mem[wa] <= wd;
    end
  end

  // Two asynchronous read ports, one per source bus.
  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];
endmodule

// File: rtl/tribus_alu.sv
module tribus_alu
  import tribus_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_op_t       op,
  input  logic [DW-1:0] bus_a,
  input  logic [DW-1:0] bus_b,
  output logic [DW-1:0] bus_c
);
  always_comb begin
    unique case (op)
      ALU_ADD:    bus_c = bus_a + bus_b;
      default:    bus_c = bus_b;
    endcase
  end
endmodule

// File: rtl/tribus_sequencer.sv
module tribus_sequencer
  import tribus_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   mem_done,
  output phase_t phase
);
  phase_t phase_nx;

  always_comb begin
    unique case (phase)
      PH_FETCH:  phase_nx = PH_WAIT;
      PH_WAIT:   phase_nx = mem_done ? PH_DECODE : PH_WAIT;
      PH_DECODE: phase_nx = PH_EXEC;
      default:   phase_nx = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FETCH;
    else     phase <= phase_nx;
  end

  assert_wait_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WAIT && !mem_done) |=> phase == PH_WAIT);
  assert_decode_to_exec_R5: assert property (@(posedge clk) disable iff (rst)
    phase == PH_DECODE |=> phase == PH_EXEC);
  assert_exec_returns_R7: assert property (@(posedge clk) disable iff (rst)
    phase == PH_EXEC |=> phase == PH_FETCH);
endmodule

// File: rtl/tribus_core.sv
module tribus_core
  import tribus_pkg::*;
#(
  parameter int DW      = 32,
  parameter int NREG    = 16,
  parameter int PC_STEP = 4,
  parameter int DST_LSB = 20,
  parameter int SA_LSB  = 16,
  parameter int SB_LSB  = 12,
  localparam int IW     = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_done,
  output logic [1:0]    phase,
  output logic [DW-1:0] ir,
  output logic          wb_en,
  output logic [IW-1:0] wb_idx,
  output logic [DW-1:0] wb_data,
  output logic          instr_end
);
  phase_t        ph;
  alu_op_t       alu_op;
  logic [DW-1:0] pc_q, pc_inc, mdr_q;
  logic [DW-1:0] bus_a, bus_b, bus_c, rf_b;
  logic [IW-1:0] f_dst, f_sa, f_sb;

  assign f_dst = ir[DST_LSB +: IW];
  assign f_sa  = ir[SA_LSB  +: IW];
  assign f_sb  = ir[SB_LSB  +: IW];

  tribus_sequencer u_seq (
    .clk(clk), .rst(rst), .mem_done(mem_done), .phase(ph)
  );
  assign phase = ph;

  tribus_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst),
    .ra_a(f_sa), .ra_b(f_sb), .rd_a(bus_a), .rd_b(rf_b),
    .we(ph == PH_EXEC), .wa(f_dst), .wd(bus_c)
  );

  // Source bus B is shared by PC (fetch), MDR (decode) and port B (execute).
  always_comb begin
    unique case (ph)
      PH_FETCH:  bus_b = pc_q;
      PH_DECODE: bus_b = mdr_q;
      default:   bus_b = rf_b;
    endcase
  end
  assign alu_op = (ph == PH_EXEC) ? ALU_ADD : ALU_PASS_B;

  tribus_alu #(.DW(DW)) u_alu (
    .op(alu_op), .bus_a(bus_a), .bus_b(bus_b), .bus_c(bus_c)
  );

  // Dedicated PC incrementer, independent of the ALU adder.
  assign pc_inc = pc_q + DW'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mdr_q     <= '0;
      ir        <= '0;
      wb_en     <= 1'b0;
      wb_idx    <= '0;
      wb_data   <= '0;
      instr_end <= 1'b0;
    end else begin
      wb_en     <= 1'b0;
      instr_end <= 1'b0;
      unique case (ph)
        PH_FETCH: begin
          mem_addr <= bus_c;
          pc_q     <= pc_inc;
          mem_rd   <= 1'b1;
        end
        PH_WAIT: begin
          if (mem_done) begin
            mdr_q  <= mem_rdata;
            mem_rd <= 1'b0;
          end
        end
        PH_DECODE: ir <= bus_c;
        default: begin
          wb_en     <= 1'b1;
          wb_idx    <= f_dst;
          wb_data   <= bus_c;
          instr_end <= 1'b1;
        end
      endcase
    end
  end

  assert_pc_advance_R2: assert property (@(posedge clk) disable iff (rst)
    ph == PH_FETCH |=> pc_q == $past(pc_q) + DW'(PC_STEP));
  assert_rd_only_waiting_R3: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> ph == PH_WAIT);
  assert_ir_only_decode_R5: assert property (@(posedge clk) disable iff (rst)
    $past(ph) != PH_DECODE |-> $stable(ir));
  assert_wb_from_exec_R6: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> ($past(ph) == PH_EXEC && instr_end && ph == PH_FETCH));
endmodule

// File: tb/tribus_core_tb.sv
module tribus_core_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_rdata, ir, wb_data;
  logic        mem_rd, mem_done, wb_en, instr_end;
  logic [1:0]  phase;
  logic [3:0]  wb_idx;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] model [16];
  logic [31:0] next_pc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tribus_core u_dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_done(mem_done), .phase(phase), .ir(ir),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .instr_end(instr_end)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    mem_done = 0; mem_rdata = 0; rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(phase == 0, "R1 phase in reset", 32'(phase), 0);
    rst = 0;
    @(negedge clk);
    chk(phase == 1 && mem_rd == 1, "R1 leaves reset into fetch then wait", 32'(phase), 1);
    // Back up: bench expects to start at a fetch step, so redo reset cleanly.
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk(phase == 0, "R1 phase after reset", 32'(phase), 0);
    chk(!mem_rd && !wb_en && !instr_end, "R1 strobes low", {29'd0, mem_rd, wb_en, instr_end}, 0);
    chk(ir == 0, "R1 ir cleared", ir, 0);
    for (int k = 0; k < 16; k++) model[k] = 32'(k);
    next_pc = 0;
  endtask

  // One complete instruction: dst = sa + sb, with memory latency and an
  // optional stray completion strobe during decode.
  task automatic run_add(input int dst, input int sa, input int sb,
                         input int waits, input bit stray, input string tag);
    logic [31:0] instr, exp;
    instr = {8'hA5, 4'(dst), 4'(sa), 4'(sb), 12'h3C9};
    exp = model[sa] + model[sb];
    @(negedge clk);
    chk(phase == 1 && mem_rd, {tag, " R2 read after fetch"}, 32'(phase), 1);
    chk(mem_addr == next_pc, {tag, " R2 fetch address"}, mem_addr, next_pc);
    chk(!wb_en && !instr_end, {tag, " R7 pulses last one cycle"}, 32'(wb_en), 0);
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);
      chk(phase == 1 && mem_rd && mem_addr == next_pc, {tag, " R3 wait holds"},
          32'(phase), 1);
    end
    mem_done = 1; mem_rdata = instr;
    @(negedge clk);
    mem_done = 0; mem_rdata = 32'hDEAD_BEEF;
    chk(phase == 2 && !mem_rd, {tag, " R4 completion taken"}, 32'(phase), 2);
    if (stray) mem_done = 1;
    @(negedge clk);
    mem_done = 0;
    chk(phase == 3, {tag, " R5 decode to execute"}, 32'(phase), 3);
    chk(ir == instr, {tag, " R5/R8 ir captured"}, ir, instr);
    @(negedge clk);
    chk(wb_en && wb_idx == 4'(dst), {tag, " R6 write index"}, 32'(wb_idx), 32'(dst));
    chk(wb_data == exp, {tag, " R6/R9 sum"}, wb_data, exp);
    chk(instr_end && phase == 0, {tag, " R7 end and return"}, 32'(phase), 0);
    model[dst] = exp;
    next_pc += 4;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    run_add(1, 2, 3, 0, 0, "basic");      // R6: seeded 2+3
    run_add(4, 1, 1, 3, 0, "latency");    // R3 with 3 wait cycles
    run_add(5, 5, 5, 1, 0, "self");       // R9: 5+5 reads old value
    run_add(6, 5, 4, 0, 1, "stray");      // R8: stray completion in decode
    run_add(15, 14, 0, 2, 0, "edges");    // R6: top and bottom indices
    run_add(7, 15, 6, 0, 0, "chain");     // R9: uses values written earlier
    for (int i = 0; i < 8; i++) run_add(8, 8, 8, i % 3, 0, "double");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule